// File: doc/BRIEF.md
# Per-Codeword PN Additive Scrambler

This block whitens a Reed-Solomon codeword stream with a pseudo-noise sequence. A 58-stage generator is reloaded with an alternating seed at the first beat of every codeword. Its output is XORed onto the data, so scrambling and descrambling are the same operation. A mode input selects one of two codeword lengths, 5280 or 4440 bits by default. A bit counter checks that each new codeword start arrives only after the selected length has run out.

The same block also carries the transcoded-header protection. On a beat flagged as the head of a 257-bit transcoded word, header lanes 0..4 are XORed with lanes 8..12. A direction input places this step before the PN XOR on transmit and after it on receive, so a receive pass undoes a transmit pass. Beats carrying alignment-marker bits can be flagged for bypass. They then pass unmodified, and the generator and the counter hold.

Data moves W bits per beat, with lane 0 first in stream order. The registered output follows the input by one clock. Each codeword length must be a multiple of W, and W must be at least 13.

Top module: `pn_cw_scrambler`

## Requirements
- R1: While reset is asserted and right after it, outValid, lenErr and outData are all 0.
- R2: outValid equals inValid of the previous cycle. Output data of a processed beat appears one clock after that beat is accepted.
- R3: On a beat with cwStart=1, the generator starts from the seed. The seed has stage 57 = 1 and each lower stage the inverse of the one above it (stage i = 1 exactly when i is odd). Each PN bit is stage57 XOR stage38, and that bit is shifted in at stage 0. PN bit j of the beat is XORed onto data lane j.
- R4: On processed beats without cwStart, the generator continues from the state the previous processed beat left, advancing W steps per beat.
- R5: With rxDir=0 and hdrStart=1, output lane k (k=0..4) is in[k]^in[k+8]^pn[k]. All other lanes are in^pn.
- R6: With rxDir=1 and hdrStart=1, output lane k (k=0..4) is (in[k]^pn[k])^(in[k+8]^pn[k+8]). All other lanes are in^pn.
- R7: A valid beat with amBypass=1 is output unchanged. It ignores cwStart and hdrStart. The generator and the bit counter hold across it, so the next processed beat continues the sequence.
- R8: modeShort=0 selects LEN_LONG bits per codeword and modeShort=1 selects LEN_SHORT. lenErr goes high for one cycle, aligned with the output, when cwStart comes on a processed beat while the counter is inside a codeword. A start exactly after the length has elapsed gives no error.
- R9: Feeding transmit output (rxDir=0) back through the block with rxDir=1 and the same start and header flags restores the original data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input beat is valid |
| inData | input | W | Input bits, lane 0 first in stream order |
| cwStart | input | 1 | Beat is the first of a codeword |
| hdrStart | input | 1 | Lanes 0..12 hold the head of a 257-bit transcoded word |
| amBypass | input | 1 | Beat carries alignment-marker bits; pass it unscrambled |
| modeShort | input | 1 | 0: LEN_LONG codeword, 1: LEN_SHORT codeword |
| rxDir | input | 1 | 0: transmit ordering, 1: receive ordering of the header XOR |
| outValid | output | 1 | Output beat is valid |
| outData | output | W | Scrambled or descrambled bits |
| lenErr | output | 1 | Codeword start arrived before the length elapsed |

## Verification
The bench builds the block with W=40, LEN_LONG=400 and LEN_SHORT=280, so a codeword is only 10 or 7 beats long. That makes it practical to step every beat of whole codewords in both modes, through several boundaries, and to land early starts at several counter positions. The short lengths also bring within reach bypass beats placed mid-codeword, header beats in both directions, and a full transmit-then-receive round trip. These are all checked against a generator model computed arithmetically from the stated seed and taps.

// File: rtl/pn_cw_scrambler_pkg.sv
package pn_cw_scrambler_pkg;
  localparam int PN_LEN = 58;
  localparam int PN_TAP_HI = 57;
  localparam int PN_TAP_LO = 38;
  localparam int HDR_BITS = 5;
  localparam int HDR_OFS = 8;

  // Alternating seed: stage 57 set, each lower stage inverted.
  function automatic logic [PN_LEN-1:0] pnSeed();
    logic [PN_LEN-1:0] s;
    for (int i = 0; i < PN_LEN; i++) s[i] = (i % 2) == 1;
    return s;
  endfunction

  typedef struct packed {
    logic advance;   // processed beat: scramble and step generator
    logic loadSeed;  // generator restarts from seed this beat
    logic hdrApply;  // apply header lane XOR this beat
    logic pass;      // bypass beat, output unchanged
  } ctlStrobe_t;
endpackage

// File: rtl/pn_cw_scrambler_ctrl.sv
module pn_cw_scrambler_ctrl
  import pn_cw_scrambler_pkg::*;
#(
  parameter int W = 40,
  parameter int LEN_LONG = 5280,
  parameter int LEN_SHORT = 4440
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       cwStart,
  input  logic       hdrStart,
  input  logic       amBypass,
  input  logic       modeShort,
  output ctlStrobe_t ctl,
  output logic       lenErr
);
  localparam int BEATS_LONG = LEN_LONG / W;
  localparam int BEATS_SHORT = LEN_SHORT / W;
  localparam int CW = $clog2(BEATS_LONG + 1);
  localparam logic [CW-1:0] BL = CW'(BEATS_LONG);
  localparam logic [CW-1:0] BS = CW'(BEATS_SHORT);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] beatCnt;
  logic [CW-1:0] beatsSel;
  logic [CW-1:0] cntInc;

  always_comb begin
    ctl.advance  = inValid && !amBypass;
    ctl.loadSeed = inValid && !amBypass && cwStart;
    ctl.hdrApply = inValid && !amBypass && hdrStart;
    ctl.pass     = inValid && amBypass;
    beatsSel     = modeShort ? BS : BL;
    cntInc       = ctl.loadSeed ? ONE : beatCnt + ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beatCnt <= '0;
      lenErr  <= 1'b0;
    end else begin
      lenErr <= ctl.loadSeed && (beatCnt != '0);
      if (ctl.advance) beatCnt <= (cntInc >= beatsSel) ? '0 : cntInc;
    end
  end

  AST_ERR_NEEDS_START: assert property (@(posedge clk) disable iff (!rstN)
    lenErr |-> $past(inValid && cwStart && !amBypass)); // R8
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    beatCnt < BL); // R8
  AST_CNT_HOLD_BYPASS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && amBypass) |=> $stable(beatCnt)); // R7
endmodule

// File: rtl/pn_cw_scrambler_dpath.sv
module pn_cw_scrambler_dpath
  import pn_cw_scrambler_pkg::*;
#(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctlStrobe_t   ctl,
  input  logic         inValid,
  input  logic         rxDir,
  input  logic [W-1:0] inData,
  output logic         outValid,
  output logic [W-1:0] outData
);
  localparam logic [PN_LEN-1:0] SEED = pnSeed();

  logic [PN_LEN-1:0] lfsr;
  logic [PN_LEN-1:0] lfsrNext;
  logic [W-1:0]      pnBits;
  logic [W-1:0]      txWord;
  logic [W-1:0]      rxWord;
  logic [W-1:0]      scrWord;

  always_comb begin
    logic [PN_LEN-1:0] st;
    logic fb;
    st = ctl.loadSeed ? SEED : lfsr;
    for (int j = 0; j < W; j++) begin
      fb = st[PN_TAP_HI] ^ st[PN_TAP_LO];
      pnBits[j] = fb;
      st = {st[PN_LEN-2:0], fb};
    end
    lfsrNext = st;
  end

  always_comb begin
    txWord = inData;
    rxWord = inData ^ pnBits;
    if (ctl.hdrApply) begin
      for (int k = 0; k < HDR_BITS; k++) begin
        txWord[k] = inData[k] ^ inData[k+HDR_OFS];
        rxWord[k] = rxWord[k] ^ rxWord[k+HDR_OFS];
      end
    end
    scrWord = rxDir ? rxWord : (txWord ^ pnBits);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsr     <= SEED;
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= inValid;
      if (ctl.advance) begin
        lfsr    <= lfsrNext;
        outData <= scrWord;
      end else if (ctl.pass) begin
        outData <= inData;
      end
    end
  end

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pass |=> (outData == $past(inData))); // R7
  AST_GEN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.advance |=> $stable(lfsr)); // R7
  AST_OUT_VALID: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(inValid)); // R2
  AST_NONHDR_LANES: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && !ctl.hdrApply) |=> (outData == $past(inData ^ pnBits))); // R4
endmodule

// File: rtl/pn_cw_scrambler.sv
module pn_cw_scrambler
  import pn_cw_scrambler_pkg::*;
#(
  parameter int W = 40,
  parameter int LEN_LONG = 5280,
  parameter int LEN_SHORT = 4440
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [W-1:0] inData,
  input  logic         cwStart,
  input  logic         hdrStart,
  input  logic         amBypass,
  input  logic         modeShort,
  input  logic         rxDir,
  output logic         outValid,
  output logic [W-1:0] outData,
  output logic         lenErr
);
  ctlStrobe_t ctl;

  pn_cw_scrambler_ctrl #(.W(W), .LEN_LONG(LEN_LONG), .LEN_SHORT(LEN_SHORT)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .cwStart(cwStart),
    .hdrStart(hdrStart), .amBypass(amBypass), .modeShort(modeShort),
    .ctl(ctl), .lenErr(lenErr)
  );

  pn_cw_scrambler_dpath #(.W(W)) uDpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inValid(inValid), .rxDir(rxDir),
    .inData(inData), .outValid(outValid), .outData(outData)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!outValid && !lenErr && outData == '0)); // R1
endmodule

// File: tb/sim_pn_cw_scrambler.sv
module sim_pn_cw_scrambler;
  localparam int W = 40;
  localparam int LL = 400;
  localparam int LS = 280;

  logic clk = 0;
  logic rstN = 0;
  logic inValid = 0, cwStart = 0, hdrStart = 0, amBypass = 0, modeShort = 0, rxDir = 0;
  logic [W-1:0] inData = '0;
  logic outValid, lenErr;
  logic [W-1:0] outData;

  int vecs = 0, errs = 0;
  logic [57:0] mState;
  int mCnt;
  logic [W-1:0] capD [0:15];
  logic [W-1:0] capQ [0:15];
  logic [W-1:0] got;

  always #5 clk = ~clk;

  pn_cw_scrambler #(.W(W), .LEN_LONG(LL), .LEN_SHORT(LS)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .cwStart(cwStart),
    .hdrStart(hdrStart), .amBypass(amBypass), .modeShort(modeShort), .rxDir(rxDir),
    .outValid(outValid), .outData(outData), .lenErr(lenErr)
  );

  function automatic logic [57:0] seedVal();
    logic [57:0] s;
    for (int i = 0; i < 58; i++) s[i] = (i % 2) == 1;
    return s;
  endfunction

  function automatic logic [W-1:0] mix(int i);
    logic [63:0] t;
    t = 64'(i + 7) * 64'h9E3779B97F4A7C15;
    return t[W-1:0] ^ t[63:64-W];
  endfunction

  task automatic beat(input logic v, input logic st, input logic hd, input logic byp,
                      input logic sh, input logic rx, input logic [W-1:0] d,
                      input string tag, output logic [W-1:0] q);
    logic [W-1:0] pn, expD, t;
    logic [57:0] s;
    logic expErr, fb;
    int beats, c;
    expErr = 0;
    expD = d;
    inValid = v; cwStart = st; hdrStart = hd; amBypass = byp;
    modeShort = sh; rxDir = rx; inData = d;
    if (v && !byp) begin
      s = st ? seedVal() : mState;
      for (int j = 0; j < W; j++) begin
        fb = s[57] ^ s[38];
        pn[j] = fb;
        s = {s[56:0], fb};
      end
      mState = s;
      expErr = st && (mCnt != 0);
      beats = sh ? LS / W : LL / W;
      c = st ? 1 : mCnt + 1;
      mCnt = (c >= beats) ? 0 : c;
      if (rx) begin
        t = d ^ pn;
        if (hd) for (int k = 0; k < 5; k++) t[k] = t[k] ^ t[k+8];
        expD = t;
      end else begin
        t = d;
        if (hd) for (int k = 0; k < 5; k++) t[k] = d[k] ^ d[k+8];
        expD = t ^ pn;
      end
    end
    @(posedge clk);
    @(negedge clk);
    q = outData;
    vecs++;
    if (outValid !== v || lenErr !== expErr || (v && outData !== expD)) begin
      errs++;
      $display("FAIL %s data=%h exp=%h valid=%b exp=%b err=%b exp=%b",
               tag, outData, expD, outValid, v, lenErr, expErr);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    mState = seedVal();
    mCnt = 0;
    repeat (3) @(negedge clk);
    vecs++;
    if (outValid !== 0 || lenErr !== 0 || outData !== '0) begin
      errs++;
      $display("FAIL R1 reset outputs data=%h valid=%b err=%b exp 0", outData, outValid, lenErr);
    end
    rstN = 1;
    @(negedge clk);
    vecs++;
    if (outValid !== 0 || lenErr !== 0 || outData !== '0) begin
      errs++;
      $display("FAIL R1 post-reset data=%h valid=%b err=%b exp 0", outData, outValid, lenErr);
    end

    // R3 R4 R5: long codewords in transmit, header on some beats
    for (int cw = 0; cw < 3; cw++)
      for (int b = 0; b < LL / W; b++)
        beat(1, b == 0, (b % 3) == 0, 0, 0, 0, mix(cw * 16 + b), "R3_R4_R5", got);
    // R2: idle cycles
    beat(0, 0, 0, 0, 0, 0, '0, "R2", got);
    beat(0, 0, 0, 0, 0, 0, '0, "R2", got);
    // R8 R7: short codewords with bypass beats mid-codeword, exact boundary starts
    for (int cw = 0; cw < 3; cw++)
      for (int b = 0; b < LS / W; b++) begin
        beat(1, b == 0, b == 2, 0, 1, 0, mix(100 + cw * 16 + b), "R8", got);
        if (b == 3) beat(1, 1, 1, 1, 1, 0, mix(200 + cw), "R7", got);
      end
    // R8: early starts at several counter positions
    for (int e = 1; e < 6; e++) begin
      beat(1, 1, 0, 0, 0, 0, mix(300 + e), "R8", got);
      for (int b = 1; b < e; b++) beat(1, 0, 0, 0, 0, 0, mix(310 + b), "R8", got);
    end
    beat(1, 1, 0, 0, 0, 0, mix(320), "R8", got);
    // R6: receive direction with header beats
    for (int b = 0; b < LS / W; b++)
      beat(1, b == 0, (b % 2) == 0, 0, 1, 1, mix(400 + b), "R6", got);
    // R9: round trip
    for (int b = 0; b < LL / W; b++) begin
      capD[b] = mix(500 + b);
      beat(1, b == 0, b < 3, 0, 0, 0, capD[b], "R9", got);
      capQ[b] = got;
    end
    for (int b = 0; b < LL / W; b++) begin
      beat(1, b == 0, b < 3, 0, 0, 1, capQ[b], "R9", got);
      vecs++;
      if (got !== capD[b]) begin
        errs++;
        $display("FAIL R9 roundtrip beat %0d data=%h exp=%h", b, got, capD[b]);
      end
    end
    beat(0, 0, 0, 0, 0, 0, '0, "R2", got);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule